// File: doc/BRIEF.md
# Power Mode and Test Control Decoder

This block sits between the control pins of a wideband modulator-plus-synthesizer front end and its serial configuration registers. It merges four hardware pins (a global run pin, a transmit-enable pin, a synthesizer-enable pin and an LO-buffer-enable pin) with the software control bits (a run bit, a transmit bit, a buffer bit, a six-bit test code and the charge-pump current selection). From them it produces one enable each for the modulator, the synthesizer, the LO buffer and the serial interface. It also produces the charge-pump source and sink overrides, the charge-pump current code and a relative current scale, and the value shown on the lock pin.

All outputs are registered in the system clock domain. Every output reflects the inputs sampled at the previous rising edge. A three-bit status code tells firmware or a neighbouring block which operating mode is in force. A subsystem runs only when its pin and its register bit agree. The run pin overrides everything. Clearing the software run bit keeps only the serial interface alive. Two test codes replace the lock status on the lock pin with one of the divider outputs.

Top module: `power_mode_ctrl`

## Requirements
- R1: `mod_en` is 1 only when `pin_run`, `reg_run`, `pin_tx` and `reg_tx` are all 1; any 0 among `pin_tx`/`reg_tx` turns it off.
- R2: `buf_en` is 1 only when `pin_run`, `reg_run`, `pin_buf` and `reg_buf` are all 1.
- R3: When `pin_run` is 0, every enable (including `sif_en`), both charge-pump overrides and `lock_pin` are 0 and `mode_status` is 0, whatever the other inputs.
- R4: When `pin_run` is 1 and `reg_run` is 0, `sif_en` is 1 and `mod_en`, `syn_en`, `buf_en` are 0; `mode_status` is 1.
- R5: `syn_en` equals `pin_run & reg_run & pin_syn`; with `pin_syn` 0 the modulator still follows R1 and `mode_status` is 4 when it runs.
- R6: While `syn_en` is 1, test code 6'b000001 sets `cp_src_force`, 6'b000010 sets `cp_snk_force`; otherwise both are 0, and they are never 1 together.
- R7: While `syn_en` is 1, `lock_pin` shows `ref_div_tick` for test code 6'b010000, `main_div_tick` for 6'b011000 and `lock_det` for any other code; while `syn_en` is 0 it is 0.
- R8: Test codes other than 000001, 000010, 010000 and 011000 behave exactly like 000000.
- R9: `cp_code` is {`reg_cp_dbl`, `reg_cp_sel`} and `cp_scale` is (`reg_cp_sel`+1), doubled when `reg_cp_dbl` is 1.
- R10: `mode_status` codes: 0 hardware off, 1 software off, 2 synthesizer only (pin_tx low), 3 software mute (pin_tx high, reg_tx low), 4 modulator with external PLL (modulator on, pin_syn low), 5 all active; tested in that priority order.
- R11: Outputs change one clock after the inputs are sampled; a synchronous `rst` clears every output to 0 (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_run | input | 1 | Hardware run pin, low shuts everything down |
| pin_tx | input | 1 | Hardware modulator enable pin |
| pin_syn | input | 1 | Hardware synthesizer enable pin |
| pin_buf | input | 1 | Hardware LO buffer enable pin |
| reg_run | input | 1 | Software run bit, low powers down all but the serial interface |
| reg_tx | input | 1 | Software modulator enable bit |
| reg_buf | input | 1 | Software LO buffer enable bit |
| reg_test | input | TEST_W | Software test code |
| reg_cp_sel | input | CP_SEL_W | Charge-pump current select |
| reg_cp_dbl | input | 1 | Charge-pump current doubling bit |
| lock_det | input | 1 | PLL lock status |
| ref_div_tick | input | 1 | Reference divider output |
| main_div_tick | input | 1 | Main divider output |
| mod_en | output | 1 | Modulator enable |
| syn_en | output | 1 | Synthesizer enable |
| buf_en | output | 1 | LO buffer enable |
| sif_en | output | 1 | Serial interface enable |
| cp_src_force | output | 1 | Charge pump forced to source |
| cp_snk_force | output | 1 | Charge pump forced to sink |
| lock_pin | output | 1 | Lock pin value |
| cp_code | output | CP_SEL_W+1 | Effective charge-pump current code |
| cp_scale | output | CP_SEL_W+2 | Relative charge-pump current |
| mode_status | output | 3 | Operating mode code |

## Verification
The assertions assume the inputs are stable around the rising edge, so each registered output can be compared with the inputs seen one edge earlier. They also assume `rst` is held from time zero until the first edge. A live flag keeps them silent on the first edge after reset, where the outputs still hold their cleared values. The stimulus changes inputs only on falling edges and reads outputs on the next falling edge. Reset is driven from the start of the run, so every comparison refers to inputs that were actually sampled.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MODE_HW_OFF     = 3'd0,
        MODE_SW_OFF     = 3'd1,
        MODE_SYNTH_ONLY = 3'd2,
        MODE_MUTE       = 3'd3,
        MODE_MOD_ONLY   = 3'd4,
        MODE_FULL       = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        LK_STATUS  = 2'd0,
        LK_REFDIV  = 2'd1,
        LK_MAINDIV = 2'd2
    } lock_src_e;

    typedef struct packed {
        logic mod_en;
        logic syn_en;
        logic buf_en;
        logic sif_en;
    } enables_t;

    typedef struct packed {
        logic src;
        logic snk;
        lock_src_e lsel;
    } test_ctl_t;

    // Priority: hardware off, software off, then modulator state.
    function automatic mode_e classify(input logic run_p, input logic run_r,
                                       input logic tx_p, input logic mod_on,
                                       input logic syn_p);
        if (!run_p)      return MODE_HW_OFF;
        else if (!run_r) return MODE_SW_OFF;
        else if (mod_on) return syn_p ? MODE_FULL : MODE_MOD_ONLY;
        else if (!tx_p)  return MODE_SYNTH_ONLY;
        else             return MODE_MUTE;
    endfunction

endpackage

// File: rtl/pmc_gate.sv
module pmc_gate
    import pmc_pkg::*;
(
    input  logic     pin_run,
    input  logic     pin_tx,
    input  logic     pin_syn,
    input  logic     pin_buf,
    input  logic     reg_run,
    input  logic     reg_tx,
    input  logic     reg_buf,
    output enables_t en,
    output mode_e    mode
);
    logic alive;

    always_comb begin
        alive     = pin_run & reg_run;
        en.sif_en = pin_run;
        en.mod_en = alive & pin_tx & reg_tx;
        en.syn_en = alive & pin_syn;
        en.buf_en = alive & pin_buf & reg_buf;
        mode      = classify(pin_run, reg_run, pin_tx, en.mod_en, pin_syn);
    end
endmodule

// File: rtl/pmc_test.sv
module pmc_test
    import pmc_pkg::*;
#(
    parameter int TEST_W = 6,
    parameter logic [TEST_W-1:0] CODE_SRC  = 6'b000001,
    parameter logic [TEST_W-1:0] CODE_SNK  = 6'b000010,
    parameter logic [TEST_W-1:0] CODE_REF  = 6'b010000,
    parameter logic [TEST_W-1:0] CODE_MAIN = 6'b011000,
    parameter bit GATE_LOCK = 1'b1
) (
    input  logic [TEST_W-1:0] code,
    input  logic              syn_on,
    input  logic              lock_det,
    input  logic              ref_tick,
    input  logic              main_tick,
    output test_ctl_t         ctl,
    output logic              lock_val
);
    logic routed;

    always_comb begin
        ctl.src  = syn_on && (code == CODE_SRC);
        ctl.snk  = syn_on && (code == CODE_SNK);
        if (code == CODE_REF)       ctl.lsel = LK_REFDIV;
        else if (code == CODE_MAIN) ctl.lsel = LK_MAINDIV;
        else                        ctl.lsel = LK_STATUS;
        case (ctl.lsel)
            LK_REFDIV:  routed = ref_tick;
            LK_MAINDIV: routed = main_tick;
            default:    routed = lock_det;
        endcase
    end

    generate
        if (GATE_LOCK) begin : g_gated
            assign lock_val = routed & syn_on;
        end else begin : g_open
            assign lock_val = routed;
        end
    endgenerate
endmodule

// File: rtl/pmc_cp.sv
module pmc_cp #(
    parameter int CP_SEL_W = 2,
    localparam int SCALE_W = CP_SEL_W + 2
) (
    input  logic [CP_SEL_W-1:0] sel,
    input  logic                dbl,
    output logic [CP_SEL_W:0]   code,
    output logic [SCALE_W-1:0]  scale
);
    logic [SCALE_W-1:0] base;

    always_comb begin
        code  = {dbl, sel};
        base  = {2'b00, sel} + SCALE_W'(1);
        scale = dbl ? (base << 1) : base;
    end
endmodule

// File: rtl/power_mode_ctrl.sv
module power_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int TEST_W   = 6,
    parameter int CP_SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pin_run,
    input  logic                  pin_tx,
    input  logic                  pin_syn,
    input  logic                  pin_buf,
    input  logic                  reg_run,
    input  logic                  reg_tx,
    input  logic                  reg_buf,
    input  logic [TEST_W-1:0]     reg_test,
    input  logic [CP_SEL_W-1:0]   reg_cp_sel,
    input  logic                  reg_cp_dbl,
    input  logic                  lock_det,
    input  logic                  ref_div_tick,
    input  logic                  main_div_tick,
    output logic                  mod_en,
    output logic                  syn_en,
    output logic                  buf_en,
    output logic                  sif_en,
    output logic                  cp_src_force,
    output logic                  cp_snk_force,
    output logic                  lock_pin,
    output logic [CP_SEL_W:0]     cp_code,
    output logic [CP_SEL_W+1:0]   cp_scale,
    output logic [2:0]            mode_status
);
    localparam int SCALE_W = CP_SEL_W + 2;

    enables_t           en_c;
    mode_e              mode_c;
    test_ctl_t          tst_c;
    logic               lock_c;
    logic [CP_SEL_W:0]  code_c;
    logic [SCALE_W-1:0] scale_c;
    logic               live;

    pmc_gate u_gate (
        .pin_run (pin_run), .pin_tx (pin_tx), .pin_syn (pin_syn), .pin_buf (pin_buf),
        .reg_run (reg_run), .reg_tx (reg_tx), .reg_buf (reg_buf),
        .en (en_c), .mode (mode_c)
    );

    pmc_test #(.TEST_W(TEST_W)) u_test (
        .code (reg_test), .syn_on (en_c.syn_en), .lock_det (lock_det),
        .ref_tick (ref_div_tick), .main_tick (main_div_tick),
        .ctl (tst_c), .lock_val (lock_c)
    );

    pmc_cp #(.CP_SEL_W(CP_SEL_W)) u_cp (
        .sel (reg_cp_sel), .dbl (reg_cp_dbl), .code (code_c), .scale (scale_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_en       <= 1'b0;
            syn_en       <= 1'b0;
            buf_en       <= 1'b0;
            sif_en       <= 1'b0;
            cp_src_force <= 1'b0;
            cp_snk_force <= 1'b0;
            lock_pin     <= 1'b0;
            cp_code      <= '0;
            cp_scale     <= '0;
            mode_status  <= MODE_HW_OFF;
            live         <= 1'b0;
        end else begin
            mod_en       <= en_c.mod_en;
            syn_en       <= en_c.syn_en;
            buf_en       <= en_c.buf_en;
            sif_en       <= en_c.sif_en;
            cp_src_force <= tst_c.src;
            cp_snk_force <= tst_c.snk;
            lock_pin     <= lock_c;
            cp_code      <= code_c;
            cp_scale     <= scale_c;
            mode_status  <= mode_c;
            live         <= 1'b1;
        end
    end

    AST_MOD_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        live && mod_en |-> $past(pin_tx) && $past(reg_tx)); // R1
    AST_BUF_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        live && buf_en |-> $past(pin_buf) && $past(reg_buf)); // R2
    AST_HW_OFF_ALL: assert property (@(posedge clk) disable iff (rst)
        live && !$past(pin_run) |-> !sif_en && !mod_en && !syn_en && !buf_en
                                     && !lock_pin && mode_status == 3'd0); // R3
    AST_SW_OFF_KEEPS_SIF: assert property (@(posedge clk) disable iff (rst)
        live && $past(pin_run) && !$past(reg_run)
            |-> sif_en && !mod_en && !syn_en && !buf_en); // R4
    AST_SYN_PIN_GATES: assert property (@(posedge clk) disable iff (rst)
        live && !$past(pin_syn) |-> !syn_en && !cp_src_force && !cp_snk_force); // R5
    AST_CP_FORCE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({cp_src_force, cp_snk_force}) <= 1); // R6
    AST_LOCK_NEEDS_SYN: assert property (@(posedge clk) disable iff (rst)
        lock_pin |-> syn_en); // R7
    AST_MODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        mode_status <= 3'd5); // R10
endmodule

// File: tb/power_mode_ctrl_test.sv
module power_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    // vector: {run, swrun, ptx, stx, psyn, pbuf, sbuf, test[6], lock, ref, main,
    //          exp mod, syn, buf, sif, src, snk, lock, mode[3]}
    localparam logic [25:0] VEC [NV] = '{
        {7'b1111111, 6'b000000, 3'b100, 4'b1111, 2'b00, 1'b1, 3'd5}, // R10 full
        {7'b0111111, 6'b000001, 3'b111, 4'b0000, 2'b00, 1'b0, 3'd0}, // R3
        {7'b1011111, 6'b000010, 3'b111, 4'b0001, 2'b00, 1'b0, 3'd1}, // R4
        {7'b1101111, 6'b000000, 3'b100, 4'b0111, 2'b00, 1'b1, 3'd2}, // R1 pin off
        {7'b1110111, 6'b000000, 3'b000, 4'b0111, 2'b00, 1'b0, 3'd3}, // R1 bit off
        {7'b1111011, 6'b000001, 3'b111, 4'b1011, 2'b00, 1'b0, 3'd4}, // R5
        {7'b1111101, 6'b000000, 3'b100, 4'b1101, 2'b00, 1'b1, 3'd5}, // R2 pin off
        {7'b1111110, 6'b000000, 3'b000, 4'b1101, 2'b00, 1'b0, 3'd5}, // R2 bit off
        {7'b1111111, 6'b000001, 3'b000, 4'b1111, 2'b10, 1'b0, 3'd5}, // R6 source
        {7'b1111111, 6'b000010, 3'b000, 4'b1111, 2'b01, 1'b0, 3'd5}, // R6 sink
        {7'b1111111, 6'b010000, 3'b010, 4'b1111, 2'b00, 1'b1, 3'd5}, // R7 ref
        {7'b1111111, 6'b010000, 3'b100, 4'b1111, 2'b00, 1'b0, 3'd5}, // R7 ref
        {7'b1111111, 6'b011000, 3'b001, 4'b1111, 2'b00, 1'b1, 3'd5}, // R7 main
        {7'b1111111, 6'b011000, 3'b110, 4'b1111, 2'b00, 1'b0, 3'd5}, // R7 main
        {7'b1111111, 6'b000011, 3'b100, 4'b1111, 2'b00, 1'b1, 3'd5}, // R8
        {7'b1111111, 6'b111111, 3'b011, 4'b1111, 2'b00, 1'b0, 3'd5}, // R8
        {7'b0011111, 6'b000000, 3'b111, 4'b0000, 2'b00, 1'b0, 3'd0}, // R10 prio
        {7'b1101011, 6'b000000, 3'b100, 4'b0011, 2'b00, 1'b0, 3'd2}, // R5 R10
        {7'b1100111, 6'b000000, 3'b100, 4'b0111, 2'b00, 1'b1, 3'd2}  // R10 prio
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_run = 0, pin_tx = 0, pin_syn = 0, pin_buf = 0;
    logic reg_run = 0, reg_tx = 0, reg_buf = 0;
    logic [5:0] reg_test = '0;
    logic [1:0] reg_cp_sel = '0;
    logic reg_cp_dbl = 0, lock_det = 0, ref_div_tick = 0, main_div_tick = 0;
    logic mod_en, syn_en, buf_en, sif_en, cp_src_force, cp_snk_force, lock_pin;
    logic [2:0] cp_code;
    logic [3:0] cp_scale;
    logic [2:0] mode_status;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    power_mode_ctrl uut (
        .clk (clk), .rst (rst),
        .pin_run (pin_run), .pin_tx (pin_tx), .pin_syn (pin_syn), .pin_buf (pin_buf),
        .reg_run (reg_run), .reg_tx (reg_tx), .reg_buf (reg_buf),
        .reg_test (reg_test), .reg_cp_sel (reg_cp_sel), .reg_cp_dbl (reg_cp_dbl),
        .lock_det (lock_det), .ref_div_tick (ref_div_tick), .main_div_tick (main_div_tick),
        .mod_en (mod_en), .syn_en (syn_en), .buf_en (buf_en), .sif_en (sif_en),
        .cp_src_force (cp_src_force), .cp_snk_force (cp_snk_force), .lock_pin (lock_pin),
        .cp_code (cp_code), .cp_scale (cp_scale), .mode_status (mode_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] outs();
        return {mod_en, syn_en, buf_en, sif_en, cp_src_force, cp_snk_force,
                lock_pin, mode_status};
    endfunction

    task automatic drive(input logic [15:0] v);
        {pin_run, reg_run, pin_tx, reg_tx, pin_syn, pin_buf, reg_buf} = v[15:9];
        reg_test = v[8:3];
        {lock_det, ref_div_tick, main_div_tick} = v[2:0];
    endtask

    initial begin
        // R11 reset with every input active
        drive(16'b1111111_000001_111);
        reg_cp_sel = 2'b11; reg_cp_dbl = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset outputs", {22'd0, outs()}, 32'd0);
        check("R11 reset cp", {25'd0, cp_code, cp_scale}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][25:10]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R1-group vector %0d (R3 R4 R5 R6 R7 R8 R10)", i),
                  {22'd0, outs()}, {22'd0, VEC[i][9:0]});
        end

        // R9 every current code
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 4; s++) begin
                reg_cp_sel = 2'(s); reg_cp_dbl = 1'(d);
                @(posedge clk);
                @(negedge clk);
                check("R9 cp_code", {29'd0, cp_code}, 32'(d * 4 + s));
                check("R9 cp_scale", {28'd0, cp_scale}, 32'((s + 1) * (d + 1)));
            end
        end

        // R11 one-cycle latency: output holds until the next edge
        drive(16'b1111111_000000_100);
        @(posedge clk);
        @(negedge clk);
        drive(16'b0111111_000000_100);
        #1;
        check("R11 holds before edge", {31'd0, sif_en}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        check("R11 R3 after edge", {22'd0, outs()}, 32'd0);

        // R6 source code ignored with synthesizer off, visible again when on
        drive(16'b1111011_000001_100);
        @(posedge clk);
        @(negedge clk);
        check("R6 src gated", {30'd0, cp_src_force, cp_snk_force}, 32'd0);
        drive(16'b1111111_000001_100);
        @(posedge clk);
        @(negedge clk);
        check("R6 src restored", {30'd0, cp_src_force, cp_snk_force}, 32'd2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule